// File: doc/BRIEF.md
# Hardwired Single-Bus Control Sequencer

This block is the control unit for a processor datapath in which every register and the ALU share one internal bus. The datapath holds a program counter, a memory address register, a memory data register, an instruction register, an operand latch in front of the ALU, a result latch after the ALU, a mux that feeds the ALU either a constant four or the operand latch, and a set of general registers. The datapath and the memory sit outside this block. The sequencer drives the gating and ALU control lines for the current time slot. It reads three things to do this: the instruction word, the memory-complete handshake and the negative condition flag.

A one-hot step counter holds the slots T1 to T8. It advances once per clock while the run input is high, and it returns to T1 when the end line is raised. In any slot that waits for memory, it stays put until the memory reports completion. An instruction decoder turns the opcode into one line per instruction class. A purely combinational encoder forms each control line as a sum of products of step lines and instruction lines. The supported sequences are the common three-step fetch, an add whose first operand comes from memory at a register-held address, a PC-relative jump, and a jump taken only when the negative flag is set.

Top module: `hw_seq_ctrl`

## Requirements
- R1: During and after reset the step output is T1 (`step` equals 1, bit 0 meaning T1, bit k meaning T(k+1)), and only one step bit is ever set.
- R2: In T1 the outputs `pc_out`, `mar_in`, `rd_req`, `sel_four`, `alu_add` and `z_in` are high and every other control line is low, for every instruction.
- R3: In T2 the outputs `z_out`, `pc_in`, `y_in` and `wmfc` are high. The counter stays in any slot with `wmfc` high until `mfc` is 1, and leaves on the edge where `mfc` is 1.
- R4: In T3 only `mdr_out` and `ir_in` are high.
- R5: For opcode 1 (bits [15:12] of `ir`, with the address register index in bits [11:8] and the destination index in bits [7:4]), the outputs are as follows. T4 raises `gpr_out` with `gpr_out_sel`=address index, plus `mar_in` and `rd_req`. T5 raises `gpr_out` with `gpr_out_sel`=destination index, plus `y_in` and `wmfc`. T6 raises `mdr_out`, `alu_add` and `z_in`, with `sel_four` low. T7 raises `z_out`, `gpr_in` with `gpr_in_sel`=destination index, and `end_op`.
- R6: For opcode 2 (unconditional jump), T4 raises `off_out`, `alu_add` and `z_in`. T5 raises `z_out`, `pc_in` and `end_op`.
- R7: For opcode 3 (jump if negative) with `n_flag`=1, the sequence is as in R6: T4 has no `end_op` and T5 ends. With `n_flag`=0, T4 raises `off_out`, `alu_add`, `z_in` and `end_op`, and the instruction ends at T4.
- R8: At most one of `pc_out`, `mdr_out`, `z_out`, `gpr_out`, `off_out` is high in any cycle, and `z_in` and `z_out` never share a slot.
- R9: While `run` is 0, every control line is 0, both register selects are 0, and the step counter holds its value.
- R10: On a clock edge with `end_op` high the counter returns to T1.
- R11: Any opcode other than 1, 2 or 3 finishes at T4, where only `end_op` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables stepping and all control outputs |
| mfc | input | 1 | Memory transfer complete |
| n_flag | input | 1 | Negative condition flag |
| ir | input | IR_W | Current instruction word |
| pc_out | output | 1 | PC drives bus |
| pc_in | output | 1 | PC loads from bus |
| mar_in | output | 1 | Address register loads from bus |
| rd_req | output | 1 | Memory read request |
| mdr_out | output | 1 | Data register drives bus |
| ir_in | output | 1 | Instruction register loads |
| y_in | output | 1 | Operand latch loads |
| sel_four | output | 1 | ALU input mux: 1 = constant four, 0 = operand latch |
| alu_add | output | 1 | ALU adds |
| z_in | output | 1 | Result latch loads |
| z_out | output | 1 | Result latch drives bus |
| gpr_out | output | 1 | Selected general register drives bus |
| gpr_in | output | 1 | Selected general register loads |
| off_out | output | 1 | IR offset field drives bus |
| wmfc | output | 1 | Slot waits for memory completion |
| end_op | output | 1 | Last slot of the instruction |
| gpr_out_sel | output | RIDX_W | Index of the register driving the bus |
| gpr_in_sel | output | RIDX_W | Index of the register loading |
| step | output | STEPS | One-hot current slot |

## Verification
The encoder is driven through each instruction class: the memory add, the jump, the conditional jump with the flag set and with it clear, and an undefined opcode. Comparing these separates the slots that are shared by all instructions from the terms that belong to one class. The two conditional-jump runs show whether the flag changes only the end slot. The memory handshake is held low for several cycles in both waiting slots, which tells a real stall apart from a counter that advances freely. Dropping `run` partway through fetch shows that both the outputs and the slot freeze.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int STEPS_MIN = 7;

    typedef struct packed {
        logic pc_out;
        logic pc_in;
        logic mar_in;
        logic rd_req;
        logic mdr_out;
        logic ir_in;
        logic y_in;
        logic sel_four;
        logic alu_add;
        logic z_in;
        logic z_out;
        logic gpr_out;
        logic gpr_in;
        logic off_out;
        logic wmfc;
        logic end_op;
    } ctl_t;

    typedef struct packed {
        logic is_add;
        logic is_br;
        logic is_brn;
        logic is_other;
    } ins_t;

    localparam logic [3:0] OPC_ADD = 4'd1;
    localparam logic [3:0] OPC_BR  = 4'd2;
    localparam logic [3:0] OPC_BRN = 4'd3;
endpackage

// File: rtl/seq_ins_dec.sv
module seq_ins_dec
    import seq_pkg::*;
#(
    parameter int IR_W   = 16,
    parameter int RIDX_W = 4
) (
    input  logic [IR_W-1:0]   ir,
    output ins_t              ins,
    output logic [RIDX_W-1:0] src_idx,
    output logic [RIDX_W-1:0] dst_idx
);
    localparam int OP_LSB  = IR_W - 4;
    localparam int SRC_LSB = OP_LSB - RIDX_W;
    localparam int DST_LSB = SRC_LSB - RIDX_W;

    logic [3:0] opc;

    always_comb begin
        opc          = ir[IR_W-1:OP_LSB];
        src_idx      = ir[SRC_LSB +: RIDX_W];
        dst_idx      = ir[DST_LSB +: RIDX_W];
        ins          = '0;
        ins.is_add   = (opc == OPC_ADD);
        ins.is_br    = (opc == OPC_BR);
        ins.is_brn   = (opc == OPC_BRN);
        ins.is_other = !(ins.is_add || ins.is_br || ins.is_brn);
    end
endmodule

// File: rtl/seq_step_ctr.sv
module seq_step_ctr
    import seq_pkg::*;
#(
    parameter int STEPS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             end_op,
    input  logic             wmfc,
    input  logic             mfc,
    output logic [STEPS-1:0] step
);
    localparam logic [STEPS-1:0] T1_LINE = {{(STEPS-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [STEPS-1:0] step;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            if (end_op) begin
                st_d.step = T1_LINE;
            end else if (wmfc && !mfc) begin
                st_d.step = st_q.step;
            end else begin
                st_d.step = {st_q.step[STEPS-2:0], st_q.step[STEPS-1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.step <= T1_LINE;
        end else begin
            st_q <= st_d;
        end
    end

    assign step = st_q.step;

    a_r1_step_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(st_q.step));

    a_r10_end_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run && end_op) |=> (st_q.step == T1_LINE));

    a_r3_mfc_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wmfc && !mfc && !end_op) |=> $stable(st_q.step));

    a_r9_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> $stable(st_q.step));
endmodule

// File: rtl/seq_encoder.sv
module seq_encoder
    import seq_pkg::*;
#(
    parameter int STEPS  = 8,
    parameter int RIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEPS-1:0]  step,
    input  ins_t              ins,
    input  logic              n_flag,
    input  logic              run,
    input  logic [RIDX_W-1:0] src_idx,
    input  logic [RIDX_W-1:0] dst_idx,
    output ctl_t              ctl,
    output logic [RIDX_W-1:0] out_sel,
    output logic [RIDX_W-1:0] in_sel
);
    logic t1, t2, t3, t4, t5, t6, t7;
    logic jump_go;

    always_comb begin
        t1 = step[0];
        t2 = step[1];
        t3 = step[2];
        t4 = step[3];
        t5 = step[4];
        t6 = step[5];
        t7 = step[6];
        jump_go = ins.is_br || (ins.is_brn && n_flag);

        ctl          = '0;
        ctl.pc_out   = t1;
        ctl.mar_in   = t1 || (t4 && ins.is_add);
        ctl.rd_req   = t1 || (t4 && ins.is_add);
        ctl.sel_four = t1;
        ctl.alu_add  = t1 || (t6 && ins.is_add) || (t4 && (ins.is_br || ins.is_brn));
        ctl.z_in     = t1 || (t6 && ins.is_add) || (t4 && (ins.is_br || ins.is_brn));
        ctl.z_out    = t2 || (t7 && ins.is_add) || (t5 && jump_go);
        ctl.pc_in    = t2 || (t5 && jump_go);
        ctl.y_in     = t2 || (t5 && ins.is_add);
        ctl.wmfc     = t2 || (t5 && ins.is_add);
        ctl.mdr_out  = t3 || (t6 && ins.is_add);
        ctl.ir_in    = t3;
        ctl.gpr_out  = (t4 || t5) && ins.is_add;
        ctl.gpr_in   = t7 && ins.is_add;
        ctl.off_out  = t4 && (ins.is_br || ins.is_brn);
        ctl.end_op   = (t7 && ins.is_add)
                     || (t5 && ins.is_br)
                     || (ins.is_brn && ((t5 && n_flag) || (t4 && !n_flag)))
                     || (t4 && ins.is_other);

        out_sel = '0;
        in_sel  = '0;
        if (ins.is_add && t4) out_sel = src_idx;
        if (ins.is_add && t5) out_sel = dst_idx;
        if (ins.is_add && t7) in_sel  = dst_idx;

        if (!run) begin
            ctl     = '0;
            out_sel = '0;
            in_sel  = '0;
        end
    end

    a_r8_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ctl.pc_out, ctl.mdr_out, ctl.z_out, ctl.gpr_out, ctl.off_out}) <= 1);

    a_r8_z_split: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.z_in && ctl.z_out));

    a_r9_quiet_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |-> (ctl == '0 && out_sel == '0 && in_sel == '0));

    a_r3_wait_only_mem_slot: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.wmfc |-> !ctl.end_op);
endmodule

// File: rtl/hw_seq_ctrl.sv
module hw_seq_ctrl
    import seq_pkg::*;
#(
    parameter int IR_W   = 16,
    parameter int RIDX_W = 4,
    parameter int STEPS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mfc,
    input  logic              n_flag,
    input  logic [IR_W-1:0]   ir,
    output logic              pc_out,
    output logic              pc_in,
    output logic              mar_in,
    output logic              rd_req,
    output logic              mdr_out,
    output logic              ir_in,
    output logic              y_in,
    output logic              sel_four,
    output logic              alu_add,
    output logic              z_in,
    output logic              z_out,
    output logic              gpr_out,
    output logic              gpr_in,
    output logic              off_out,
    output logic              wmfc,
    output logic              end_op,
    output logic [RIDX_W-1:0] gpr_out_sel,
    output logic [RIDX_W-1:0] gpr_in_sel,
    output logic [STEPS-1:0]  step
);
    ins_t              ins;
    ctl_t              ctl;
    logic [RIDX_W-1:0] src_idx;
    logic [RIDX_W-1:0] dst_idx;

    initial begin
        if (STEPS < STEPS_MIN) $error("STEPS too small for the add sequence");
        if (IR_W < 4 + 2 * RIDX_W) $error("IR_W too narrow for opcode and two indices");
    end

    seq_ins_dec #(.IR_W(IR_W), .RIDX_W(RIDX_W)) u_dec (
        .ir      (ir),
        .ins     (ins),
        .src_idx (src_idx),
        .dst_idx (dst_idx)
    );

    seq_step_ctr #(.STEPS(STEPS)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .end_op (ctl.end_op),
        .wmfc   (ctl.wmfc),
        .mfc    (mfc),
        .step   (step)
    );

    seq_encoder #(.STEPS(STEPS), .RIDX_W(RIDX_W)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .ins     (ins),
        .n_flag  (n_flag),
        .run     (run),
        .src_idx (src_idx),
        .dst_idx (dst_idx),
        .ctl     (ctl),
        .out_sel (gpr_out_sel),
        .in_sel  (gpr_in_sel)
    );

    assign pc_out   = ctl.pc_out;
    assign pc_in    = ctl.pc_in;
    assign mar_in   = ctl.mar_in;
    assign rd_req   = ctl.rd_req;
    assign mdr_out  = ctl.mdr_out;
    assign ir_in    = ctl.ir_in;
    assign y_in     = ctl.y_in;
    assign sel_four = ctl.sel_four;
    assign alu_add  = ctl.alu_add;
    assign z_in     = ctl.z_in;
    assign z_out    = ctl.z_out;
    assign gpr_out  = ctl.gpr_out;
    assign gpr_in   = ctl.gpr_in;
    assign off_out  = ctl.off_out;
    assign wmfc     = ctl.wmfc;
    assign end_op   = ctl.end_op;
endmodule

// File: tb/sim_hw_seq_ctrl.sv
module sim_hw_seq_ctrl;
    localparam int CLK_P = 10;

    localparam logic [15:0] PCO = 16'h8000;
    localparam logic [15:0] PCI = 16'h4000;
    localparam logic [15:0] MAI = 16'h2000;
    localparam logic [15:0] RDQ = 16'h1000;
    localparam logic [15:0] MDO = 16'h0800;
    localparam logic [15:0] IRI = 16'h0400;
    localparam logic [15:0] YIN = 16'h0200;
    localparam logic [15:0] SL4 = 16'h0100;
    localparam logic [15:0] ADD = 16'h0080;
    localparam logic [15:0] ZIN = 16'h0040;
    localparam logic [15:0] ZOU = 16'h0020;
    localparam logic [15:0] GPO = 16'h0010;
    localparam logic [15:0] GPI = 16'h0008;
    localparam logic [15:0] OFO = 16'h0004;
    localparam logic [15:0] WMF = 16'h0002;
    localparam logic [15:0] ENDL = 16'h0001;

    localparam logic [15:0] W_T1 = PCO | MAI | RDQ | SL4 | ADD | ZIN;
    localparam logic [15:0] W_T2 = ZOU | PCI | YIN | WMF;
    localparam logic [15:0] W_T3 = MDO | IRI;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic mfc = 1'b0;
    logic n_flag = 1'b0;
    logic [15:0] ir = '0;
    logic pc_out, pc_in, mar_in, rd_req, mdr_out, ir_in, y_in, sel_four;
    logic alu_add, z_in, z_out, gpr_out, gpr_in, off_out, wmfc, end_op;
    logic [3:0] gpr_out_sel, gpr_in_sel;
    logic [7:0] step;

    typedef struct {
        string       tag;
        logic [15:0] word;
        logic [3:0]  osel;
        logic [3:0]  isel;
        logic [7:0]  stp;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    hw_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .mfc(mfc), .n_flag(n_flag), .ir(ir),
        .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .rd_req(rd_req),
        .mdr_out(mdr_out), .ir_in(ir_in), .y_in(y_in), .sel_four(sel_four),
        .alu_add(alu_add), .z_in(z_in), .z_out(z_out), .gpr_out(gpr_out),
        .gpr_in(gpr_in), .off_out(off_out), .wmfc(wmfc), .end_op(end_op),
        .gpr_out_sel(gpr_out_sel), .gpr_in_sel(gpr_in_sel), .step(step)
    );

    // monitor: pops one expected item per cycle, in the middle of the cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            logic [15:0] w;
            e = sb.pop_front();
            w = {pc_out, pc_in, mar_in, rd_req, mdr_out, ir_in, y_in, sel_four,
                 alu_add, z_in, z_out, gpr_out, gpr_in, off_out, wmfc, end_op};
            checks++;
            if (w !== e.word || gpr_out_sel !== e.osel || gpr_in_sel !== e.isel
                || step !== e.stp) begin
                errors++;
                $display("FAIL %s: ctl=%h osel=%0d isel=%0d step=%b expected ctl=%h osel=%0d isel=%0d step=%b",
                         e.tag, w, gpr_out_sel, gpr_in_sel, step,
                         e.word, e.osel, e.isel, e.stp);
            end
        end
    end

    // driver: apply inputs for one cycle and queue what must be seen in it
    task automatic cyc(input string tag, input logic r, input logic m, input logic n,
                       input logic [15:0] wd, input logic [3:0] os, input logic [3:0] is,
                       input int slot);
        exp_t e;
        run = r;
        mfc = m;
        n_flag = n;
        e.tag  = tag;
        e.word = wd;
        e.osel = os;
        e.isel = is;
        e.stp  = 8'b1 << (slot - 1);
        sb.push_back(e);
        @(posedge clk);
        #1;
    endtask

    task automatic fetch(input logic n, input int stall);
        cyc("R2 fetch T1", 1, 0, n, W_T1, 0, 0, 1);
        for (int i = 0; i < stall; i++) cyc("R3 T2 stall", 1, 0, n, W_T2, 0, 0, 2);
        cyc("R3 T2 mfc", 1, 1, n, W_T2, 0, 0, 2);
        cyc("R4 T3", 1, 0, n, W_T3, 0, 0, 3);
    endtask

    initial begin
        #(CLK_P * 2000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        #1;
        cyc("R1 reset state", 1, 0, 0, W_T1, 0, 0, 1);
        rst_n = 1'b1;

        // R5: add, address reg 3, destination 1, with stalls in both wait slots
        ir = 16'h1310;
        fetch(0, 2);
        cyc("R5 T4", 1, 0, 0, GPO | MAI | RDQ, 4'd3, 0, 4);
        cyc("R5 T5 stall", 1, 0, 0, GPO | YIN | WMF, 4'd1, 0, 5);
        cyc("R3 T5 stall", 1, 0, 0, GPO | YIN | WMF, 4'd1, 0, 5);
        cyc("R5 T5 mfc", 1, 1, 0, GPO | YIN | WMF, 4'd1, 0, 5);
        cyc("R5 T6", 1, 0, 0, MDO | ADD | ZIN, 0, 0, 6);
        cyc("R5 T7", 1, 0, 0, ZOU | GPI | ENDL, 0, 4'd1, 7);

        // R9: halt at T1, then R10 shows restart landed on T1; R6 jump
        ir = 16'h2005;
        cyc("R9 halt", 0, 1, 0, 16'h0, 0, 0, 1);
        cyc("R9 halt hold", 0, 1, 0, 16'h0, 0, 0, 1);
        fetch(0, 0);
        cyc("R9 halt mid", 0, 1, 0, 16'h0, 0, 0, 4);
        cyc("R6 T4", 1, 0, 0, OFO | ADD | ZIN, 0, 0, 4);
        cyc("R6 T5", 1, 0, 0, ZOU | PCI | ENDL, 0, 0, 5);

        // R7 taken
        ir = 16'h3ff0;
        fetch(1, 1);
        cyc("R7 taken T4", 1, 0, 1, OFO | ADD | ZIN, 0, 0, 4);
        cyc("R7 taken T5", 1, 0, 1, ZOU | PCI | ENDL, 0, 0, 5);

        // R7 not taken
        fetch(0, 0);
        cyc("R7 not taken T4", 1, 0, 0, OFO | ADD | ZIN | ENDL, 0, 0, 4);

        // R11 undefined opcode, right after R10 restart
        ir = 16'h9abc;
        fetch(1, 0);
        cyc("R11 other T4", 1, 0, 1, ENDL, 0, 0, 4);
        cyc("R10 back at T1", 1, 0, 0, W_T1, 0, 0, 1);

        // R5 with other indices, R8 bus check implied by exact words
        ir = 16'h1c70;
        cyc("R3 T2 no mfc", 1, 0, 0, W_T2, 0, 0, 2);
        cyc("R3 T2 mfc", 1, 1, 0, W_T2, 0, 0, 2);
        cyc("R4 T3", 1, 0, 0, W_T3, 0, 0, 3);
        cyc("R5 T4 idx", 1, 0, 0, GPO | MAI | RDQ, 4'd12, 0, 4);
        cyc("R5 T5 idx", 1, 1, 0, GPO | YIN | WMF, 4'd7, 0, 5);
        cyc("R8 T6", 1, 0, 0, MDO | ADD | ZIN, 0, 0, 6);
        cyc("R8 T7", 1, 0, 0, ZOU | GPI | ENDL, 0, 4'd7, 7);
        cyc("R1 restart T1", 1, 0, 0, W_T1, 0, 0, 1);

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule